// File: doc/BRIEF.md
# Load Value Renaming Predictor

This block lets a processor use a load's result before the load has computed its effective address. Each store or load is tracked in a small table keyed by instruction address. An entry in that table points to a slot in a value file. A producing store and the load that consumes its datum are made to share one slot. When the store executes, it writes its data into the slot. When the load dispatches, it reads the slot and receives a value it may use speculatively.

Links are learned at verification. A load's actual address and data return from the data cache. If that address equals one of the last few stores' addresses, the load's table entry is repointed at that store's value slot. A two-bit confidence counter per entry gates speculation. The pipeline returns the value it was given together with the actual data. Any speculated value that differs raises a one-cycle mispredict pulse, which starts state recovery.

Top module: `rn_load_renamer`

## Requirements
- R1: After reset, no table entry is valid: every dispatch lookup returns `lk_hit`=0 and `lk_spec`=0, and `mispredict` is 0.
- R2: A store (`st_valid`=1) whose PC misses allocates the entry at index PC[5:2], with value slot number equal to that index and confidence 0. The store's data is written into the entry's value slot. A lookup with the same PC in the next cycle hits and returns that data.
- R3: The dispatch lookup is combinational: `lk_hit`, `lk_spec` and `lk_value` reflect `ld_pc` in the same cycle, using table state as of the last clock edge.
- R4: When a verify (`vfy_valid`=1) has `vfy_addr` equal to the address of a store in the window, the load's entry points to that store's value slot from the next cycle. A missing entry is allocated, and confidence is cleared whenever the slot changes.
- R5: On a verify that hits an entry and keeps its slot, confidence rises by one when `vfy_pred` equals `vfy_data`, saturating at 3. On a mismatch it drops to 0.
- R6: `lk_spec` is 1 only when the lookup hits and the entry's confidence is 2 or 3.
- R7: `mispredict` is 1 for exactly the cycle after a verify with `vfy_spec`=1 and `vfy_pred`≠`vfy_data`, and 0 in every other cycle.
- R8: A later store with the same PC overwrites the shared slot, and a linked load then reads the new value.
- R9: A PC that selects a valid entry but carries a different tag misses, and no value is speculated.
- R10: A confident entry that hands out a stale value, as happens with loop-carried dependences, is still reported as a mispredict when it is verified. After that its confidence is 0.
- R11: The store window holds only the 4 most recent stores. An address older than that forms no link. When two window stores have the same address, the newer one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_pc | input | PC_W | PC of the load being dispatched |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_spec | output | 1 | Value is confident enough to speculate |
| lk_value | output | DATA_W | Value read from the linked slot |
| st_valid | input | 1 | A store executes this cycle |
| st_pc | input | PC_W | Store PC |
| st_addr | input | ADDR_W | Store effective address |
| st_data | input | DATA_W | Store data |
| vfy_valid | input | 1 | A load's cache result is being verified |
| vfy_pc | input | PC_W | PC of the verified load |
| vfy_addr | input | ADDR_W | Actual load address |
| vfy_data | input | DATA_W | Actual data from the cache |
| vfy_spec | input | 1 | The load used the speculative value |
| vfy_pred | input | DATA_W | Value the load was given at dispatch |
| mispredict | output | 1 | One-cycle recovery request |

## Verification
The hardest state to reach is a fully confident entry whose value has gone stale. Reaching it takes a store, a linking verify, and enough correct verifies to pass the threshold and reach saturation. A verify then has to carry a prediction that no longer matches the cache data. The stimulus builds this chain one step at a time, checking confidence through `lk_spec` after each step. The store window is then pushed past its depth with four fresh stores, so that an old address no longer links. Two stores to the same address show that the newer one is chosen.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef logic [1:0] conf_t;
  localparam conf_t CONF_SPEC = 2'd2;
  localparam conf_t CONF_MAX  = 2'd3;

  function automatic conf_t conf_bump(conf_t c);
    return (c == CONF_MAX) ? c : c + 2'd1;
  endfunction
endpackage

// File: rtl/rn_value_file.sv
module rn_value_file #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  // data array: written only when a store executes; no reset needed,
  // since reads are qualified by a valid table entry
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/rn_store_window.sv
module rn_store_window #(
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 4,
  parameter int VF_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [ADDR_W-1:0]   push_addr,
  input  logic [VF_IDX_W-1:0] push_vfi,
  input  logic [ADDR_W-1:0]   srch_addr,
  output logic                srch_hit,
  output logic [VF_IDX_W-1:0] srch_vfi
);
  // slot 0 is the newest store
  logic                v_q [DEPTH];
  logic                v_d [DEPTH];
  logic [ADDR_W-1:0]   a_q [DEPTH];
  logic [ADDR_W-1:0]   a_d [DEPTH];
  logic [VF_IDX_W-1:0] x_q [DEPTH];
  logic [VF_IDX_W-1:0] x_d [DEPTH];

  always_comb begin
    v_d = v_q;
    a_d = a_q;
    x_d = x_q;
    if (push) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        v_d[i] = v_q[i-1];
        a_d[i] = a_q[i-1];
        x_d[i] = x_q[i-1];
      end
      v_d[0] = 1'b1;
      a_d[0] = push_addr;
      x_d[0] = push_vfi;
    end
  end

  // scan oldest to newest so the newest match is the one kept
  always_comb begin
    srch_hit = 1'b0;
    srch_vfi = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (v_q[i] && a_q[i] == srch_addr) begin
        srch_hit = 1'b1;
        srch_vfi = x_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) v_q[i] <= 1'b0;
    end else if (push) begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      a_q <= a_d;
      x_q <= x_d;
    end
  end
endmodule

// File: rtl/rn_slc.sv
module rn_slc
  import rn_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 16,
  parameter int VF_IDX_W = 4,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TAG_W   = PC_W - IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     rd_pc,
  output logic                rd_hit,
  output conf_t               rd_conf,
  output logic [VF_IDX_W-1:0] rd_vfi,
  input  logic                st_valid,
  input  logic [PC_W-1:0]     st_pc,
  output logic [VF_IDX_W-1:0] st_vfi,
  input  logic                vf_valid,
  input  logic [PC_W-1:0]     vf_pc,
  input  logic                link_valid,
  input  logic [VF_IDX_W-1:0] link_vfi,
  input  logic                train_ok
);
  function automatic logic [IDX_W-1:0] idx_of(logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
    return {pc[PC_W-1:IDX_W+2], pc[1:0]};
  endfunction

  logic                valid_q [ENTRIES];
  logic                valid_d [ENTRIES];
  logic [TAG_W-1:0]    tag_q   [ENTRIES];
  logic [TAG_W-1:0]    tag_d   [ENTRIES];
  logic [VF_IDX_W-1:0] vfi_q   [ENTRIES];
  logic [VF_IDX_W-1:0] vfi_d   [ENTRIES];
  conf_t               conf_q  [ENTRIES];
  conf_t               conf_d  [ENTRIES];

  logic [IDX_W-1:0] rd_idx, st_idx, vf_idx;
  logic             st_hit, vf_hit, upd_en;

  assign rd_idx  = idx_of(rd_pc);
  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc));
  assign rd_conf = conf_q[rd_idx];
  assign rd_vfi  = vfi_q[rd_idx];

  assign st_idx = idx_of(st_pc);
  assign st_hit = valid_q[st_idx] && (tag_q[st_idx] == tag_of(st_pc));
  assign st_vfi = st_hit ? vfi_q[st_idx] : VF_IDX_W'(st_idx);

  assign vf_idx = idx_of(vf_pc);
  assign vf_hit = valid_q[vf_idx] && (tag_q[vf_idx] == tag_of(vf_pc));
  assign upd_en = st_valid || vf_valid;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    vfi_d   = vfi_q;
    conf_d  = conf_q;
    if (st_valid && !st_hit) begin
      valid_d[st_idx] = 1'b1;
      tag_d[st_idx]   = tag_of(st_pc);
      vfi_d[st_idx]   = VF_IDX_W'(st_idx);
      conf_d[st_idx]  = '0;
    end
    // verify is applied last and wins on a shared index
    if (vf_valid) begin
      if (vf_hit) begin
        valid_d[vf_idx] = 1'b1;
        tag_d[vf_idx]   = tag_of(vf_pc);
        if (link_valid && link_vfi != vfi_q[vf_idx]) begin
          vfi_d[vf_idx]  = link_vfi;
          conf_d[vf_idx] = '0;
        end else begin
          vfi_d[vf_idx]  = vfi_q[vf_idx];
          conf_d[vf_idx] = train_ok ? conf_bump(conf_q[vf_idx]) : '0;
        end
      end else if (link_valid) begin
        valid_d[vf_idx] = 1'b1;
        tag_d[vf_idx]   = tag_of(vf_pc);
        vfi_d[vf_idx]   = link_vfi;
        conf_d[vf_idx]  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (upd_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q  <= tag_d;
      vfi_q  <= vfi_d;
      conf_q <= conf_d;
    end
  end
endmodule

// File: rtl/rn_load_renamer.sv
module rn_load_renamer
  import rn_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SLC_ENTRIES = 16,
  parameter int VF_ENTRIES  = 16,
  parameter int WIN_DEPTH   = 4,
  localparam int VF_IDX_W   = $clog2(VF_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   ld_pc,
  output logic              lk_hit,
  output logic              lk_spec,
  output logic [DATA_W-1:0] lk_value,
  input  logic              st_valid,
  input  logic [PC_W-1:0]   st_pc,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              vfy_valid,
  input  logic [PC_W-1:0]   vfy_pc,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [DATA_W-1:0] vfy_data,
  input  logic              vfy_spec,
  input  logic [DATA_W-1:0] vfy_pred,
  output logic              mispredict
);
  conf_t               rd_conf;
  logic [VF_IDX_W-1:0] rd_vfi, st_vfi, link_vfi;
  logic                link_hit, train_ok, mp_d;

  assign train_ok = (vfy_pred == vfy_data);

  rn_slc #(
    .PC_W(PC_W), .ENTRIES(SLC_ENTRIES), .VF_IDX_W(VF_IDX_W)
  ) u_slc (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(ld_pc), .rd_hit(lk_hit), .rd_conf(rd_conf), .rd_vfi(rd_vfi),
    .st_valid(st_valid), .st_pc(st_pc), .st_vfi(st_vfi),
    .vf_valid(vfy_valid), .vf_pc(vfy_pc),
    .link_valid(link_hit), .link_vfi(link_vfi), .train_ok(train_ok)
  );

  rn_value_file #(
    .DATA_W(DATA_W), .ENTRIES(VF_ENTRIES)
  ) u_vf (
    .clk(clk), .we(st_valid), .waddr(st_vfi), .wdata(st_data),
    .raddr(rd_vfi), .rdata(lk_value)
  );

  rn_store_window #(
    .ADDR_W(ADDR_W), .DEPTH(WIN_DEPTH), .VF_IDX_W(VF_IDX_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n),
    .push(st_valid), .push_addr(st_addr), .push_vfi(st_vfi),
    .srch_addr(vfy_addr), .srch_hit(link_hit), .srch_vfi(link_vfi)
  );

  assign lk_spec = lk_hit && (rd_conf >= CONF_SPEC);
  assign mp_d    = vfy_valid && vfy_spec && (vfy_pred != vfy_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mispredict <= 1'b0;
    else        mispredict <= mp_d;
  end
endmodule

// File: rtl/rn_load_renamer_sva.sv
module rn_load_renamer_sva #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   ld_pc,
  input logic              lk_hit,
  input logic              lk_spec,
  input logic [DATA_W-1:0] lk_value,
  input logic              st_valid,
  input logic [PC_W-1:0]   st_pc,
  input logic [DATA_W-1:0] st_data,
  input logic              vfy_valid,
  input logic              vfy_spec,
  input logic [DATA_W-1:0] vfy_data,
  input logic [DATA_W-1:0] vfy_pred,
  input logic              mispredict
);
  assert_store_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_valid) && !$past(vfy_valid) && ld_pc == $past(st_pc))
      |-> (lk_hit && lk_value == $past(st_data)));

  assert_spec_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_spec |-> lk_hit);

  assert_mp_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_valid && vfy_spec && vfy_pred != vfy_data) |=> mispredict);

  assert_mp_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(vfy_valid && vfy_spec && vfy_pred != vfy_data));
endmodule

bind rn_load_renamer rn_load_renamer_sva #(
  .PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .ld_pc(ld_pc), .lk_hit(lk_hit), .lk_spec(lk_spec),
  .lk_value(lk_value), .st_valid(st_valid), .st_pc(st_pc), .st_data(st_data),
  .vfy_valid(vfy_valid), .vfy_spec(vfy_spec), .vfy_data(vfy_data),
  .vfy_pred(vfy_pred), .mispredict(mispredict)
);

// File: tb/tb_rn_load_renamer.sv
`timescale 1ns/1ps
module tb_rn_load_renamer;
  localparam int SIG_HIT = 0, SIG_SPEC = 1, SIG_VAL = 2, SIG_MP = 3;

  typedef struct {
    int          cyc;
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk, rst_n;
  logic [31:0] ld_pc, st_pc, st_addr, st_data;
  logic [31:0] vfy_pc, vfy_addr, vfy_data, vfy_pred;
  logic        st_valid, vfy_valid, vfy_spec;
  logic        lk_hit, lk_spec, mispredict;
  logic [31:0] lk_value;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  rn_load_renamer dut (
    .clk(clk), .rst_n(rst_n), .ld_pc(ld_pc), .lk_hit(lk_hit), .lk_spec(lk_spec),
    .lk_value(lk_value), .st_valid(st_valid), .st_pc(st_pc), .st_addr(st_addr),
    .st_data(st_data), .vfy_valid(vfy_valid), .vfy_pc(vfy_pc), .vfy_addr(vfy_addr),
    .vfy_data(vfy_data), .vfy_spec(vfy_spec), .vfy_pred(vfy_pred),
    .mispredict(mispredict)
  );

  initial begin
    clk = 0;
    forever #2 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations due in this cycle, sampled mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sig)
        SIG_HIT:  act = {31'd0, lk_hit};
        SIG_SPEC: act = {31'd0, lk_spec};
        SIG_VAL:  act = lk_value;
        default:  act = {31'd0, mispredict};
      endcase
      checks++;
      if (it.cyc != cyc || act !== it.exp) begin
        fails++;
        $display("FAIL %s sig=%0d cyc=%0d: actual %h expected %h", it.req, it.sig, cyc, act, it.exp);
      end
    end
  end

  task automatic expect_at(int off, int sig, logic [31:0] exp, string req);
    item_t it;
    it.cyc = cyc + off; it.sig = sig; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
    st_valid = 0; vfy_valid = 0; vfy_spec = 0;
  endtask

  task automatic do_store(logic [31:0] pc, logic [31:0] addr, logic [31:0] data);
    step();
    st_valid = 1; st_pc = pc; st_addr = addr; st_data = data;
  endtask

  task automatic do_verify(logic [31:0] pc, logic [31:0] addr, logic [31:0] data,
                           logic [31:0] pred, logic spec, logic exp_mp, string req);
    step();
    vfy_valid = 1; vfy_pc = pc; vfy_addr = addr; vfy_data = data;
    vfy_pred = pred; vfy_spec = spec;
    expect_at(1, SIG_MP, {31'd0, exp_mp}, req);
  endtask

  task automatic look(logic [31:0] pc, logic hit, logic spec, logic [31:0] val, string req);
    step();
    ld_pc = pc;
    expect_at(0, SIG_HIT, {31'd0, hit}, req);
    expect_at(0, SIG_SPEC, {31'd0, spec}, req);
    if (hit) expect_at(0, SIG_VAL, val, {req, " R3"});
  endtask

  localparam logic [31:0] PS  = 32'h100;  // store PC, index 0
  localparam logic [31:0] PL  = 32'h204;  // load PC, index 1
  localparam logic [31:0] A   = 32'h4000;

  initial begin
    rst_n = 0; ld_pc = PS; st_valid = 0; vfy_valid = 0; vfy_spec = 0;
    st_pc = 0; st_addr = 0; st_data = 0;
    vfy_pc = 0; vfy_addr = 0; vfy_data = 0; vfy_pred = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    look(PS, 0, 0, 0, "R1");
    expect_at(0, SIG_MP, 0, "R1");
    look(PL, 0, 0, 0, "R1");

    do_store(PS, A, 32'h11);
    look(PS, 1, 0, 32'h11, "R2");
    look(PL, 0, 0, 0, "R4 before link");

    do_verify(PL, A, 32'h11, 32'h0, 0, 0, "R7 no spec");     // link, conf 0
    look(PL, 1, 0, 32'h11, "R4 linked");
    do_verify(PL, A, 32'h11, 32'h11, 0, 0, "R7");            // conf 1
    look(PL, 1, 0, 32'h11, "R6 conf1");
    do_verify(PL, A, 32'h11, 32'h11, 0, 0, "R7");            // conf 2
    look(PL, 1, 1, 32'h11, "R6 conf2");

    do_store(PS, A, 32'h22);
    look(PL, 1, 1, 32'h22, "R8");

    do_verify(PL, A, 32'h22, 32'h22, 1, 0, "R7 correct");    // conf 3
    look(PL, 1, 1, 32'h22, "R5 conf3");
    do_verify(PL, A, 32'h22, 32'h22, 1, 0, "R7 correct");    // saturate at 3
    look(PL, 1, 1, 32'h22, "R5 saturate");

    do_verify(PL, A, 32'h33, 32'h22, 1, 1, "R10 stale");     // conf -> 0
    look(PL, 1, 0, 32'h22, "R10 R5 cleared");
    expect_at(0, SIG_MP, 1, "R10");
    look(PL, 1, 0, 32'h22, "R5");
    expect_at(0, SIG_MP, 0, "R7 pulse");

    do_verify(PL, A, 32'h99, 32'h22, 0, 0, "R7 unspec mismatch");
    look(32'h140, 0, 0, 0, "R9 alias");

    do_store(32'h320, 32'h5000, 32'h50);
    do_store(32'h324, 32'h5004, 32'h51);
    do_store(32'h328, 32'h5008, 32'h52);
    do_store(32'h32C, 32'h500C, 32'h53);
    do_verify(32'h418, A, 32'h22, 32'h0, 0, 0, "R7");
    look(32'h418, 0, 0, 0, "R11 aged out");
    do_verify(32'h418, 32'h5004, 32'h51, 32'h0, 0, 0, "R7");
    look(32'h418, 1, 0, 32'h51, "R4 window link");

    do_store(32'h330, 32'h5004, 32'h77);
    do_verify(32'h41C, 32'h5004, 32'h77, 32'h0, 0, 0, "R7");
    look(32'h41C, 1, 0, 32'h77, "R11 newest wins");
    do_verify(32'h438, 32'h5000, 32'h50, 32'h0, 0, 0, "R7");
    look(32'h438, 0, 0, 0, "R11 depth");

    repeat (3) step();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule